// File: doc/BRIEF.md
# RTC Register Access Controller

This block is the software-facing front end of a real-time clock. It holds the time, date, prescaler and control registers that software sees, and protects them with a key-sequence write lock. Two particular bytes written in order to the lock register open the protected registers. Any other byte written there closes them again.

Loading a new time or date takes a handshake. Software raises an init request. The request crosses into the RTC timing domain through a two-stage synchroniser, which stops the calendar core and then reports that init is ready. Only then do time, date and prescaler writes land, and each accepted write fires a one-cycle load strobe toward the core.

While the calendar runs, the time and date registers act as shadow copies. They are refreshed from the core at a fixed cadence of RTC ticks, and a synchronised flag shows when that has happened. Software clears the flag to wait for the next fresh copy. The RTC clock is brought in as a tick enable (`rtc_ce`) sampled in the bus clock domain, so the whole block runs on one clock.

Top module: `rtcwp_top`

## Requirements
- R1: After reset: lock closed, status reads 0x00, control reads 0x00, time and date read 0, prescaler reads 0x007F00FF, and `cal_halt_o` is low.
- R2: Writing 0xCA and then 0x53 in the low byte of the lock register (offset 0x24) opens the lock. Writes to other offsets between the two keys do not disturb the sequence.
- R3: Any other byte written to the lock register closes it at once. A wrong byte between the two keys restarts the sequence, so a following 0x53 does not open the lock.
- R4: While the lock is closed, writes to time, date, prescaler, control and status are ignored and the registers read back unchanged.
- R5: Status (offset 0x0C) bit 7 is the init request and bit 6 is init ready. Ready and `cal_halt_o` rise on the second `rtc_ce` tick after the request is set, and fall on the second tick after it is cleared.
- R6: Time (0x00, mask 0x3F7F7F), date (0x04, mask 0xFFFF3F) and prescaler (0x10: async divider in bits 22:16, sync divider in bits 14:0) are written only while the lock is open and both request and ready are set. Each accepted write raises its load strobe for exactly the one cycle after the write edge. A write at any other time leaves the register and the strobes untouched.
- R7: Control (0x18) bit 6 is the 12-hour format bit, driven on `fmt12_o`. It is writable whenever the lock is open, inside or outside init.
- R8: Status bit 5 is the synchronised flag. Writing 0 there clears it; writing 1 has no effect. While the calendar runs, it sets on the second `rtc_ce` tick after the clear, and time and date then read back the core inputs. It never sets while the calendar is halted.
- R9: Status bit 4 reads 1 exactly when the year field (date bits 23:16) is non-zero.
- R10: `bus_rdata` shows the register at `bus_addr` one cycle later. The lock register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_ce | input | 1 | One-cycle tick per RTC clock period |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 32 | Registered read data |
| cal_time_i | input | 22 | Running time from the calendar core |
| cal_date_i | input | 24 | Running date from the calendar core |
| cal_halt_o | output | 1 | Stops the calendar core |
| ld_time_o | output | 1 | Load strobe for the time value |
| ld_date_o | output | 1 | Load strobe for the date value |
| ld_presc_o | output | 1 | Load strobe for the prescaler |
| time_o | output | 22 | Time register value |
| date_o | output | 24 | Date register value |
| presc_async_o | output | 7 | Asynchronous divider value |
| presc_sync_o | output | 15 | Synchronous divider value |
| fmt12_o | output | 1 | Hour format select |

## Verification
Results arrive on three different schedules:

- Lock changes and register writes take effect at the write edge, so they are visible to the next access.
- Read data and load strobes appear one cycle after the edge that caused them.
- Init ready, halt and the synchronised flag move only on `rtc_ce` ticks: the second tick after the triggering write.

The bench holds `rtc_ce` low except in explicit single-tick pulses. It samples on falling edges after each tick and checks the value after the first tick, where nothing may have changed yet, as well as after the second. The random phase keeps `rtc_ce` low, so shadow refresh cannot overwrite the values it predicts.

// File: rtl/rtcwp_pkg.sv
package rtcwp_pkg;
  localparam int REG_AW = 6;
  localparam int DW     = 32;
  localparam int TIME_W = 22;
  localparam int DATE_W = 24;
  localparam int PSA_W  = 7;
  localparam int PSS_W  = 15;
  localparam int PSA_LSB = 16;

  localparam logic [REG_AW-1:0] OFS_TIME  = 6'h00;
  localparam logic [REG_AW-1:0] OFS_DATE  = 6'h04;
  localparam logic [REG_AW-1:0] OFS_STAT  = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_PRESC = 6'h10;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 6'h18;
  localparam logic [REG_AW-1:0] OFS_WPROT = 6'h24;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  localparam int ST_REQ   = 7;
  localparam int ST_RDY   = 6;
  localparam int ST_SYNC  = 5;
  localparam int ST_INITD = 4;
  localparam int CTRL_FMT = 6;

  localparam logic [TIME_W-1:0] TIME_MASK = 22'h3F7F7F;
  localparam logic [DATE_W-1:0] DATE_MASK = 24'hFFFF3F;

  typedef enum logic [1:0] {LK_CLOSED, LK_HALF, LK_OPEN} lock_st_t;
endpackage

// File: rtl/rtcwp_keylock.sv
module rtcwp_keylock
  import rtcwp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wp_we,
  input  logic [7:0] wp_key,
  output logic       unlocked_o
);
  lock_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wp_we) begin
      if (wp_key == KEY_FIRST)                          st_d = LK_HALF;
      else if (st_q == LK_HALF && wp_key == KEY_SECOND) st_d = LK_OPEN;
      else                                              st_d = LK_CLOSED;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= LK_CLOSED;
    else     st_q <= st_d;
  end

  assign unlocked_o = (st_q == LK_OPEN);

  // R2
  open_needs_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked_o) |-> $past(wp_we && wp_key == KEY_SECOND));
  // R3
  relock_chk: assert property (@(posedge clk) disable iff (rst)
    (wp_we && wp_key != KEY_SECOND) |=> !unlocked_o);
endmodule

// File: rtl/rtcwp_init_sync.sv
module rtcwp_init_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rtc_ce,
  input  logic req,
  output logic ready_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)         sh_q <= '0;
    else if (rtc_ce) sh_q <= {sh_q[STAGES-2:0], req};
  end

  assign ready_o = sh_q[STAGES-1];

  // R5
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ready_o) |-> $past(rtc_ce));
endmodule

// File: rtl/rtcwp_shadow_sync.sv
module rtcwp_shadow_sync #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rtc_ce,
  input  logic run,
  input  logic clr,
  output logic refresh_o,
  output logic sync_o
);
  localparam int CNT_W = $clog2(CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign refresh_o = rtc_ce && run && !clr && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sync_o <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      sync_o <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
    end else if (rtc_ce) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q  <= '0;
        sync_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R8
  sync_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> $past(rtc_ce && run));
  // R8
  sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !sync_o);
endmodule

// File: rtl/rtcwp_top.sv
module rtcwp_top
  import rtcwp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHADOW_CYC  = 2,
  parameter logic [PSA_W-1:0] PSA_RST = 7'h7F,
  parameter logic [PSS_W-1:0] PSS_RST = 15'h00FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rtc_ce,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  output logic [DW-1:0]     bus_rdata,
  input  logic [TIME_W-1:0] cal_time_i,
  input  logic [DATE_W-1:0] cal_date_i,
  output logic              cal_halt_o,
  output logic              ld_time_o,
  output logic              ld_date_o,
  output logic              ld_presc_o,
  output logic [TIME_W-1:0] time_o,
  output logic [DATE_W-1:0] date_o,
  output logic [PSA_W-1:0]  presc_async_o,
  output logic [PSS_W-1:0]  presc_sync_o,
  output logic              fmt12_o
);
  logic unlocked, ready, sync_flag, refresh;
  logic req_q, fmt_q;
  logic [TIME_W-1:0] time_q;
  logic [DATE_W-1:0] date_q;
  logic [PSA_W-1:0]  psa_q;
  logic [PSS_W-1:0]  pss_q;
  logic ld_time_q, ld_date_q, ld_presc_q;
  logic [DW-1:0] rdata_q, rd_d;

  logic wr_open, wr_cal, stat_we, sync_clr, inited;
  assign wr_open  = bus_we && unlocked;
  assign wr_cal   = wr_open && ready && req_q;
  assign stat_we  = wr_open && bus_addr == OFS_STAT;
  assign sync_clr = stat_we && !bus_wdata[ST_SYNC];
  assign inited   = |date_q[DATE_W-1:DATE_W-8];

  rtcwp_keylock u_lock (
    .clk(clk), .rst(rst),
    .wp_we(bus_we && bus_addr == OFS_WPROT),
    .wp_key(bus_wdata[7:0]),
    .unlocked_o(unlocked)
  );

  rtcwp_init_sync #(.STAGES(SYNC_STAGES)) u_init (
    .clk(clk), .rst(rst), .rtc_ce(rtc_ce), .req(req_q), .ready_o(ready)
  );

  rtcwp_shadow_sync #(.CYC(SHADOW_CYC)) u_shadow (
    .clk(clk), .rst(rst), .rtc_ce(rtc_ce), .run(!ready), .clr(sync_clr),
    .refresh_o(refresh), .sync_o(sync_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= 1'b0;
      fmt_q      <= 1'b0;
      time_q     <= '0;
      date_q     <= '0;
      psa_q      <= PSA_RST;
      pss_q      <= PSS_RST;
      ld_time_q  <= 1'b0;
      ld_date_q  <= 1'b0;
      ld_presc_q <= 1'b0;
    end else begin
      ld_time_q  <= wr_cal && bus_addr == OFS_TIME;
      ld_date_q  <= wr_cal && bus_addr == OFS_DATE;
      ld_presc_q <= wr_cal && bus_addr == OFS_PRESC;
      if (stat_we) req_q <= bus_wdata[ST_REQ];
      if (wr_open && bus_addr == OFS_CTRL) fmt_q <= bus_wdata[CTRL_FMT];
      if (refresh) begin
        time_q <= cal_time_i & TIME_MASK;
        date_q <= cal_date_i & DATE_MASK;
      end else if (wr_cal) begin
        if (bus_addr == OFS_TIME) time_q <= bus_wdata[TIME_W-1:0] & TIME_MASK;
        if (bus_addr == OFS_DATE) date_q <= bus_wdata[DATE_W-1:0] & DATE_MASK;
      end
      if (wr_cal && bus_addr == OFS_PRESC) begin
        psa_q <= bus_wdata[PSA_LSB +: PSA_W];
        pss_q <= bus_wdata[PSS_W-1:0];
      end
    end
  end

  always_comb begin
    rd_d = '0;
    case (bus_addr)
      OFS_TIME:  rd_d[TIME_W-1:0] = time_q;
      OFS_DATE:  rd_d[DATE_W-1:0] = date_q;
      OFS_STAT: begin
        rd_d[ST_REQ]   = req_q;
        rd_d[ST_RDY]   = ready;
        rd_d[ST_SYNC]  = sync_flag;
        rd_d[ST_INITD] = inited;
      end
      OFS_PRESC: begin
        rd_d[PSA_LSB +: PSA_W] = psa_q;
        rd_d[PSS_W-1:0]        = pss_q;
      end
      OFS_CTRL:  rd_d[CTRL_FMT] = fmt_q;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_d;
  end

  assign bus_rdata     = rdata_q;
  assign cal_halt_o    = ready;
  assign ld_time_o     = ld_time_q;
  assign ld_date_o     = ld_date_q;
  assign ld_presc_o    = ld_presc_q;
  assign time_o        = time_q;
  assign date_o        = date_q;
  assign presc_async_o = psa_q;
  assign presc_sync_o  = pss_q;
  assign fmt12_o       = fmt_q;

  // R4
  locked_time_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_TIME && !unlocked && !refresh) |=> $stable(time_o));
  // R4
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_CTRL && !unlocked) |=> $stable(fmt12_o));
  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_time_o, ld_date_o, ld_presc_o}));
  // R6
  load_needs_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_time_o || ld_date_o || ld_presc_o) |-> $past(cal_halt_o && unlocked));
endmodule

// File: tb/rtcwp_top_tb.sv
module rtcwp_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rtc_ce = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [21:0] cal_time_i = '0;
  logic [23:0] cal_date_i = '0;
  logic        cal_halt_o, ld_time_o, ld_date_o, ld_presc_o, fmt12_o;
  logic [21:0] time_o;
  logic [23:0] date_o;
  logic [6:0]  presc_async_o;
  logic [14:0] presc_sync_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtcwp_top u_dut (
    .clk(clk), .rst(rst), .rtc_ce(rtc_ce), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .cal_time_i(cal_time_i), .cal_date_i(cal_date_i), .cal_halt_o(cal_halt_o),
    .ld_time_o(ld_time_o), .ld_date_o(ld_date_o), .ld_presc_o(ld_presc_o),
    .time_o(time_o), .date_o(date_o), .presc_async_o(presc_async_o),
    .presc_sync_o(presc_sync_o), .fmt12_o(fmt12_o)
  );

  function automatic logic [31:0] m_time(logic [31:0] v); return v & 32'h003F7F7F; endfunction
  function automatic logic [31:0] m_date(logic [31:0] v); return v & 32'h00FFFF3F; endfunction
  function automatic logic [31:0] m_presc(logic [31:0] v); return v & 32'h007F7FFF; endfunction
  // lock model: 0 closed, 1 first key seen, 2 open
  function automatic int next_lock(int st, logic [7:0] k);
    if (k == 8'hCA) return 1;
    if (st == 1 && k == 8'h53) return 2;
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); rtc_ce = 1'b1;
    @(negedge clk); rtc_ce = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] t_m, d_m;
    int lk;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R10 zero reads
    rd(6'h0C, r); chk("R1 status", r, 32'h0);
    rd(6'h18, r); chk("R1 control", r, 32'h0);
    rd(6'h00, r); chk("R1 time", r, 32'h0);
    rd(6'h10, r); chk("R1 prescaler", r, 32'h007F00FF);
    chk("R1 halt", {31'b0, cal_halt_o}, 32'h0);
    rd(6'h24, r); chk("R10 lock reg reads zero", r, 32'h0);
    rd(6'h08, r); chk("R10 unmapped reads zero", r, 32'h0);

    // R4 locked writes ignored
    wr(6'h18, 32'h40); rd(6'h18, r); chk("R4 locked control", r, 32'h0);
    wr(6'h0C, 32'h80); rd(6'h0C, r); chk("R4 locked status", r, 32'h0);
    wr(6'h10, 32'h0); rd(6'h10, r); chk("R4 locked prescaler", r, 32'h007F00FF);

    // R2 unlock with an unrelated write between the keys; R7 control
    wr(6'h24, 32'hCA); wr(6'h00, 32'h1); wr(6'h24, 32'h53);
    wr(6'h18, 32'hFFFF_FFFF); rd(6'h18, r); chk("R2 R7 control after unlock", r, 32'h40);
    chk("R7 fmt12_o", {31'b0, fmt12_o}, 32'h1);

    // R3 relock and restart
    wr(6'h24, 32'hFF); wr(6'h18, 32'h0); rd(6'h18, r); chk("R3 relock", r, 32'h40);
    wr(6'h24, 32'hCA); wr(6'h24, 32'h11); wr(6'h24, 32'h53);
    wr(6'h18, 32'h0); rd(6'h18, r); chk("R3 restart needed", r, 32'h40);
    wr(6'h24, 32'hCA); wr(6'h24, 32'h53);
    wr(6'h18, 32'h0); rd(6'h18, r); chk("R7 clear fmt", r, 32'h0);

    // R6 calendar write outside init ignored
    wr(6'h00, 32'h123456);
    chk("R6 no strobe outside init", {31'b0, ld_time_o}, 32'h0);
    rd(6'h00, r); chk("R6 time outside init", r, 32'h0);

    // R5 init handshake
    wr(6'h0C, 32'h80);
    chk("R5 halt before ticks", {31'b0, cal_halt_o}, 32'h0);
    tick(); chk("R5 halt after one tick", {31'b0, cal_halt_o}, 32'h0);
    tick(); chk("R5 halt after two ticks", {31'b0, cal_halt_o}, 32'h1);
    rd(6'h0C, r); chk("R5 R8 status in init", r, 32'hE0);

    // R6 loads with strobes
    wr(6'h00, 32'hFF12_3456);
    chk("R6 time strobe", {31'b0, ld_time_o}, 32'h1);
    @(negedge clk); chk("R6 time strobe one cycle", {31'b0, ld_time_o}, 32'h0);
    rd(6'h00, r); chk("R6 time value", r, m_time(32'hFF12_3456));
    wr(6'h04, 32'hFFFF_FFFF);
    chk("R6 date strobe", {31'b0, ld_date_o}, 32'h1);
    rd(6'h04, r); chk("R6 date value", r, 32'h00FFFF3F);
    rd(6'h0C, r); chk("R9 year nonzero", r, 32'hF0);
    wr(6'h04, 32'h0000_1231); rd(6'h0C, r); chk("R9 year zero", r, 32'hE0);
    wr(6'h04, 32'h0025_0615);
    wr(6'h10, 32'hFFFF_FFFF);
    chk("R6 presc strobe", {31'b0, ld_presc_o}, 32'h1);
    rd(6'h10, r); chk("R6 presc mask", r, 32'h007F7FFF);
    wr(6'h10, 32'h0003_00FF);
    chk("R6 presc outputs", {9'b0, presc_async_o, 1'b0, presc_sync_o}, 32'h000300FF);

    // R8 flag does not set while halted
    wr(6'h0C, 32'h80);
    tick(); tick(); tick();
    rd(6'h0C, r); chk("R8 halted no sync", r, 32'hD0);

    // Random phase: ticks held low, lock sequences mixed with loads
    lk = 2; t_m = m_time(32'hFF12_3456); d_m = 32'h00250615;
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [31:0] v;
      op = $urandom_range(0, 3);
      v = $urandom;
      if (op == 0) begin
        case ($urandom_range(0, 3))
          0: v = 32'hCA; 1: v = 32'h53; 2: v = 32'hFF; default: ;
        endcase
        wr(6'h24, v); lk = next_lock(lk, v[7:0]);
      end else if (op == 1) begin
        wr(6'h00, v); if (lk == 2) t_m = m_time(v);
      end else if (op == 2) begin
        wr(6'h04, v); if (lk == 2) d_m = m_date(v);
      end else begin
        wr(6'h24, 32'hCA); wr(6'h24, 32'h53); lk = 2;
      end
      rd(6'h00, r); chk("R4 R6 random time", r, t_m);
      rd(6'h04, r); chk("R4 R6 random date", r, d_m);
      rd(6'h0C, r); chk("R9 random inited", r[4], {31'b0, d_m[23:16] != 8'h0});
    end

    // R5 exit, R8 refresh after resume
    wr(6'h24, 32'hCA); wr(6'h24, 32'h53);
    rd(6'h00, r); t_m = r;
    wr(6'h0C, 32'h00);
    tick(); chk("R5 halt held one tick", {31'b0, cal_halt_o}, 32'h1);
    tick(); chk("R5 halt released", {31'b0, cal_halt_o}, 32'h0);
    cal_time_i = 22'h235959; cal_date_i = 24'h991231;
    tick(); rd(6'h0C, r); chk("R8 not yet synced", r[5], 32'h0);
    rd(6'h00, r); chk("R8 time not yet refreshed", r, t_m);
    tick(); rd(6'h0C, r); chk("R8 synced", r, 32'h30);
    rd(6'h00, r); chk("R8 refreshed time", r, 32'h235959);
    rd(6'h04, r); chk("R8 refreshed date", r, m_date(32'h991231));
    wr(6'h0C, 32'h20); rd(6'h0C, r); chk("R8 write one no effect", r, 32'h30);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule